// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs a transmit queue of four descriptors that are held in registers instead of memory. Each slot has three fields, each a 32-bit word on a small register port:

- a status word, which only the engine writes;
- a control word, which carries the buffer address, the ownership and completion flags, and a read-only copy of the engine's current slot index;
- a frame length.

Software fills in a slot's address and length and then sets its enable flag. That hands the slot to the engine.

The engine serves the slots strictly in ring order. It stays on its current slot until that slot is enabled. It then raises a send request to a frame sender that carries the slot's address and length, and waits for the acknowledge. On the acknowledge it stores the sender's status word, marks the slot done, drops its enable flag and moves to the next slot. A level interrupt stays high while any slot is marked done.

To recycle a slot, software clears its done flag (and usually rewrites its length). While a slot is owned by the engine, software writes to its control and length words are refused.

Top module: `txring_engine`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of a send, `cur_slot` is 0, `irq` and `snd_req` are low, and every control and status word reads back with only the index field, which is zero.
- R2: The register port is word addressed. `reg_waddr[1:0]` selects the field: 0 = status, 1 = control, 2 = length, 3 = reserved. The bits above it select the slot. The reserved field reads 0.
- R3: Control-word layout. Bit 0 is enable and bit 1 is done. Bits 3:2 read the engine's current slot index and are read-only. Bits 5:4 read 0. Bits 31:6 hold the buffer address, so a written value has its low six bits dropped.
- R4: The engine stays on its current slot while that slot is not enabled. One cycle after it sees the enable flag, it raises `snd_req`, with `snd_addr` equal to the slot's buffer address and `snd_len` equal to its length. It holds all three steady until `snd_ack`.
- R5: At the clock edge that samples `snd_ack` with `snd_req` high, the 14-bit `snd_status` is stored in the slot's status word. The slot's done flag is set and its enable flag is cleared. `snd_req` then falls.
- R6: After each completion the slot index becomes (index + 1) mod 4, so slot 3 wraps to slot 0. An enabled slot that is not the current one is never launched ahead of it.
- R7: `irq` is high whenever any slot's done flag is set, and low once software has cleared every done flag.
- R8: While a slot's enable flag is set, writes to its control word and its length word have no effect.
- R9: Software can only clear a done flag: writing 1 to control bit 1 leaves it unchanged. The status word ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | IDX_W+2 | Word address: slot in the upper bits, field in bits 1:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_waddr` (combinational) |
| snd_req | output | 1 | Send request to the frame sender |
| snd_addr | output | 32 | Buffer address of the slot being sent |
| snd_len | output | LEN_W | Length of the slot being sent |
| snd_ack | input | 1 | Frame sender completion |
| snd_status | input | 14 | Completion status from the frame sender |
| cur_slot | output | IDX_W | Slot the engine is on |
| irq | output | 1 | High while any slot is marked done |

## Verification
The bench builds the block with its defaults: four slots, a 14-bit length and a 14-bit status. With four slots, a short directed run reaches every slot and the wrap from slot 3 back to slot 0. The full-width status field lets a collision count of 15 pass through unchanged. A single slot can be kept busy while software tries to overwrite it. A reset can also be dropped onto a send that is still waiting for its acknowledge.

// File: rtl/txring_pkg.sv
package txring_pkg;

  localparam int STAT_W = 14;

  typedef enum logic [1:0] {
    FLD_STAT = 2'd0,
    FLD_CTRL = 2'd1,
    FLD_LEN  = 2'd2,
    FLD_RSVD = 2'd3
  } fld_e;

  typedef enum logic {
    ENG_WAIT = 1'b0,
    ENG_SEND = 1'b1
  } eng_e;

  // ring successor of a slot index
  function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
    return (idx + 1) % n;
  endfunction

  // control word image: address[31:6], zero[5:4], index[3:2], done, enable
  function automatic logic [31:0] pack_ctrl(logic [25:0] base, logic [1:0] idx,
                                            logic done, logic en);
    return {base, 2'b00, idx, done, en};
  endfunction

endpackage

// File: rtl/txring_slot_file.sv
module txring_slot_file
  import txring_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LEN_W = 14,
  parameter int IDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sw_we,
  input  logic [IDX_W-1:0]              sw_slot,
  input  fld_e                          sw_fld,
  input  logic [31:0]                   sw_wdata,
  input  logic                          wb_fire,
  input  logic [IDX_W-1:0]              wb_slot,
  input  logic [STAT_W-1:0]             wb_status,
  output logic [SLOTS-1:0]              en_vec,
  output logic [SLOTS-1:0]              done_vec,
  output logic [SLOTS-1:0][25:0]        base_arr,
  output logic [SLOTS-1:0][LEN_W-1:0]   len_arr,
  output logic [SLOTS-1:0][STAT_W-1:0]  stat_arr,
  output logic                          wr_blocked
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              en_q, done_q;
    logic [25:0]       base_q;
    logic [LEN_W-1:0]  len_q;
    logic [STAT_W-1:0] stat_q;
    logic              sel_w, hit_wb;

    assign sel_w  = sw_we   && (sw_slot == IDX_W'(s));
    assign hit_wb = wb_fire && (wb_slot == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        done_q <= 1'b0;
        base_q <= '0;
        len_q  <= '0;
        stat_q <= '0;
      end else if (hit_wb) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
        stat_q <= wb_status;
      end else if (sel_w && !en_q) begin
        case (sw_fld)
          FLD_CTRL: begin
            en_q   <= sw_wdata[0];
            done_q <= done_q & sw_wdata[1];
            base_q <= sw_wdata[31:6];
          end
          FLD_LEN:  len_q <= sw_wdata[LEN_W-1:0];
          default:  ;
        endcase
      end
    end

    assign en_vec[s]   = en_q;
    assign done_vec[s] = done_q;
    assign base_arr[s] = base_q;
    assign len_arr[s]  = len_q;
    assign stat_arr[s] = stat_q;
  end

  assign wr_blocked = sw_we && en_vec[sw_slot] &&
                      (sw_fld == FLD_CTRL || sw_fld == FLD_LEN);

endmodule

// File: rtl/txring_seq.sv
module txring_seq
  import txring_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] en_vec,
  input  logic             snd_ack,
  output logic             snd_req,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wb_fire
);

  eng_e             state_q;
  logic [IDX_W-1:0] idx_q;
  logic             launch;

  assign launch  = (state_q == ENG_WAIT) && en_vec[idx_q];
  assign wb_fire = (state_q == ENG_SEND) && snd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_WAIT;
      idx_q   <= '0;
    end else if (launch) begin
      state_q <= ENG_SEND;
    end else if (wb_fire) begin
      state_q <= ENG_WAIT;
      idx_q   <= IDX_W'(ring_next(int'(idx_q), SLOTS));
    end
  end

  assign snd_req = (state_q == ENG_SEND);
  assign cur_idx = idx_q;

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int LEN_W  = 14,
  parameter int IDX_W  = $clog2(SLOTS),
  parameter int REG_AW = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              snd_req,
  output logic [31:0]       snd_addr,
  output logic [LEN_W-1:0]  snd_len,
  input  logic              snd_ack,
  input  logic [STAT_W-1:0] snd_status,
  output logic [IDX_W-1:0]  cur_slot,
  output logic              irq
);

  logic [IDX_W-1:0]              sw_slot;
  fld_e                          sw_fld;
  logic [SLOTS-1:0]              en_vec, done_vec;
  logic [SLOTS-1:0][25:0]        base_arr;
  logic [SLOTS-1:0][LEN_W-1:0]   len_arr;
  logic [SLOTS-1:0][STAT_W-1:0]  stat_arr;
  logic                          wr_blocked;
  logic                          wb_fire;
  logic [IDX_W-1:0]              cur_idx;
  logic [1:0]                    idx_field;

  assign sw_slot = reg_waddr[REG_AW-1:2];
  assign sw_fld  = fld_e'(reg_waddr[1:0]);

  txring_slot_file #(.SLOTS(SLOTS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (reg_wr),
    .sw_slot   (sw_slot),
    .sw_fld    (sw_fld),
    .sw_wdata  (reg_wdata),
    .wb_fire   (wb_fire),
    .wb_slot   (cur_idx),
    .wb_status (snd_status),
    .en_vec    (en_vec),
    .done_vec  (done_vec),
    .base_arr  (base_arr),
    .len_arr   (len_arr),
    .stat_arr  (stat_arr),
    .wr_blocked(wr_blocked)
  );

  txring_seq #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_vec (en_vec),
    .snd_ack(snd_ack),
    .snd_req(snd_req),
    .cur_idx(cur_idx),
    .wb_fire(wb_fire)
  );

  assign idx_field = 2'(cur_idx);
  assign cur_slot  = cur_idx;
  assign snd_addr  = {base_arr[cur_idx], 6'b0};
  assign snd_len   = len_arr[cur_idx];
  assign irq       = |done_vec;

  always_comb begin
    case (sw_fld)
      FLD_STAT: reg_rdata = 32'(stat_arr[sw_slot]);
      FLD_CTRL: reg_rdata = pack_ctrl(base_arr[sw_slot], idx_field,
                                      done_vec[sw_slot], en_vec[sw_slot]);
      FLD_LEN:  reg_rdata = 32'(len_arr[sw_slot]);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk #(
  parameter int SLOTS = 4,
  parameter int IDX_W = 2,
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snd_req,
  input logic             snd_ack,
  input logic [31:0]      snd_addr,
  input logic [LEN_W-1:0] snd_len,
  input logic [IDX_W-1:0] cur_slot,
  input logic             irq,
  input logic             wb_fire,
  input logic             wr_blocked,
  input logic [SLOTS-1:0] en_vec,
  input logic [SLOTS-1:0] done_vec
);

  AST_REQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    snd_req |-> en_vec[cur_slot]); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_req && !snd_ack) |=> (snd_req && $stable(snd_addr) && $stable(snd_len))); // R4

  AST_WB_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> (!en_vec[$past(cur_slot)] && done_vec[$past(cur_slot)] && !snd_req)); // R5

  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> (cur_slot == IDX_W'((int'($past(cur_slot)) + 1) % SLOTS))); // R6

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_fire |=> $stable(cur_slot)); // R6

  AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> irq); // R7

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && !wb_fire) |=> $stable(en_vec)); // R8

  AST_DONE_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_fire |=> ($countones(done_vec & ~$past(done_vec)) == 0)); // R9

endmodule

bind txring_engine txring_engine_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .snd_req   (snd_req),
  .snd_ack   (snd_ack),
  .snd_addr  (snd_addr),
  .snd_len   (snd_len),
  .cur_slot  (cur_slot),
  .irq       (irq),
  .wb_fire   (wb_fire),
  .wr_blocked(wr_blocked),
  .en_vec    (en_vec),
  .done_vec  (done_vec)
);

// File: tb/txring_engine_bench.sv
module txring_engine_bench;

  localparam int F_STAT = 0, F_CTRL = 1, F_LEN = 2, F_RSVD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        snd_req;
  logic [31:0] snd_addr;
  logic [13:0] snd_len;
  logic        snd_ack = 1'b0;
  logic [13:0] snd_status = '0;
  logic [1:0]  cur_slot;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txring_engine u_txring_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snd_req(snd_req),
    .snd_addr(snd_addr), .snd_len(snd_len), .snd_ack(snd_ack),
    .snd_status(snd_status), .cur_slot(cur_slot), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int slot, input int fld, input logic [31:0] d);
    @(negedge clk);
    reg_waddr = 4'((slot << 2) | fld);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input int slot, input int fld, output logic [31:0] v);
    reg_waddr = 4'((slot << 2) | fld);
    #1 v = reg_rdata;
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    while (!snd_req && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(req, 32'(snd_req), 32'd1);
  endtask

  task automatic do_ack(input logic [13:0] st);
    snd_status = st;
    snd_ack    = 1'b1;
    @(negedge clk);
    snd_ack    = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R1 cur_slot", 32'(cur_slot), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 snd_req", 32'(snd_req), 0);
    for (int s = 0; s < 4; s++) begin
      reg_read(s, F_CTRL, v);
      check("R1 ctrl", v, 0);
      reg_read(s, F_STAT, v);
      check("R1 status", v, 0);
    end
  endtask

  task automatic t_single_send();
    logic [31:0] v;
    reg_write(0, F_LEN, 32'd60);
    reg_write(0, F_CTRL, 32'h1234_567F);   // low bits set: only enable takes effect
    reg_read(0, F_CTRL, v);
    check("R3 ctrl layout", v, 32'h1234_5641);
    check("R4 no request in enable cycle", 32'(snd_req), 0);
    @(negedge clk);
    check("R4 request one cycle later", 32'(snd_req), 1);
    check("R4 snd_addr", snd_addr, 32'h1234_5640);
    check("R4 snd_len", 32'(snd_len), 60);
    do_ack(14'h02A5);
    check("R5 req falls", 32'(snd_req), 0);
    check("R6 index advances", 32'(cur_slot), 1);
    check("R7 irq raised", 32'(irq), 1);
    reg_read(0, F_CTRL, v);
    check("R5 done set enable cleared", v, 32'h1234_5646);
    reg_read(0, F_STAT, v);
    check("R5 status stored", v, 32'h0000_02A5);
    reg_read(0, F_LEN, v);
    check("R2 length field", v, 60);
  endtask

  task automatic t_blocked_write();
    logic [31:0] v;
    reg_write(1, F_LEN, 32'd200);
    reg_write(1, F_CTRL, 32'h0000_0081);
    wait_req("R4 slot1 request");
    reg_write(1, F_LEN, 32'd5);
    reg_write(1, F_CTRL, 32'h0000_0000);
    reg_read(1, F_LEN, v);
    check("R8 length write ignored", v, 200);
    reg_read(1, F_CTRL, v);
    check("R8 ctrl write ignored", v, 32'h0000_0085);
    check("R8 snd_len unchanged", 32'(snd_len), 200);
    check("R4 request held", 32'(snd_req), 1);
    do_ack(14'h3C00);
    reg_read(1, F_STAT, v);
    check("R5 collision count passes", v, 32'h0000_3C00);
    check("R6 index to 2", 32'(cur_slot), 2);
  endtask

  task automatic t_done_and_irq();
    logic [31:0] v;
    reg_write(2, F_CTRL, 32'h0000_0002);
    reg_read(2, F_CTRL, v);
    check("R9 done not settable", v, 32'h0000_0008);
    reg_write(2, F_STAT, 32'h0000_FFFF);
    reg_read(2, F_STAT, v);
    check("R9 status write ignored", v, 0);
    reg_write(0, F_CTRL, 32'h1234_5640);
    check("R7 irq stays with slot1 done", 32'(irq), 1);
    reg_write(1, F_CTRL, 32'h0000_0080);
    check("R7 irq low after all cleared", 32'(irq), 0);
    reg_read(0, F_RSVD, v);
    check("R2 reserved field", v, 0);
  endtask

  task automatic t_order_and_wrap();
    reg_write(3, F_LEN, 32'd64);
    reg_write(3, F_CTRL, 32'h0000_0301);
    repeat (5) @(negedge clk);
    check("R6 no skip ahead", 32'(snd_req), 0);
    check("R6 stays on slot 2", 32'(cur_slot), 2);
    reg_write(2, F_LEN, 32'd70);
    reg_write(2, F_CTRL, 32'h0000_0201);
    wait_req("R4 slot2 request");
    check("R4 slot2 address", snd_addr, 32'h0000_0200);
    do_ack(14'h0001);
    wait_req("R4 slot3 request");
    check("R4 slot3 address", snd_addr, 32'h0000_0300);
    check("R6 on slot 3", 32'(cur_slot), 3);
    do_ack(14'h0002);
    check("R6 wrap to 0", 32'(cur_slot), 0);
    repeat (3) @(negedge clk);
    check("R4 idle on disabled slot0", 32'(snd_req), 0);
    check("R7 irq with slots 2,3 done", 32'(irq), 1);
  endtask

  task automatic t_reset_mid_send();
    logic [31:0] v;
    reg_write(0, F_CTRL, 32'h0000_0041);
    wait_req("R4 slot0 request");
    apply_reset();
    check("R1 req after reset", 32'(snd_req), 0);
    check("R1 slot after reset", 32'(cur_slot), 0);
    check("R1 irq after reset", 32'(irq), 0);
    reg_read(0, F_CTRL, v);
    check("R1 ctrl after reset", v, 0);
  endtask

  initial begin
    apply_reset();
    t_reset_state();
    t_single_send();
    t_blocked_write();
    t_done_and_irq();
    t_order_and_wrap();
    t_reset_mid_send();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

endmodule